// File: doc/BRIEF.md
# Pipeline Hazard Stall/Bubble Controller

This block is the hazard control for a five-stage in-order pipeline made of fetch, decode, execute, memory and writeback. Each cycle it looks at the operation class held in several stages, the source registers read in decode, the load destination register in execute, and whether the conditional branch in execute failed its condition. From these it works out which pipeline registers must keep their contents (stall) and which must be loaded with a no-op of normal status (bubble). It also picks where fetch takes the next address from.

The block handles three hazards. The first is a load whose result is needed at once by the next instruction. The second is a return that must wait for its target to be read from memory. The third is a conditional branch that was predicted taken but falls through. Operand forwarding is assumed to exist elsewhere, so ordinary dependences cause no stall. The logic is combinational. Its inputs are plain control pins with no handshake, because every stage presents its contents every cycle. The clock is used only by the embedded properties.

Top module: `hazard_ctrl`

## Requirements
- R1: While `rst_n` is low, `stall` is 5'b00000, `bubble` is 5'b11110 and `pc_sel` is 0. Vector bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory and bit 4 writeback.
- R2: An instruction in execute of class ALU (1), store (4), no-op (0) or other (7) writing a register read in decode causes no stall and no bubble: `stall`=0, `bubble`=0, `pc_sel`=0 (PREDICT).
- R3: When execute holds a load (class 2) or pop (class 3) whose `e_dst_m` equals `d_src_a` or `d_src_b`, then `stall`=5'b00011 and `bubble`=5'b00100. A load in the memory stage causes no such stall.
- R4: Register ID 15 means no register and never matches. A load with `e_dst_m`=15 and a decode source of 15 gives `stall`=0 and `bubble`=0.
- R5: A return (class 6) in decode, execute or memory gives `stall`=5'b00001 and `bubble`=5'b00010. A return moving through those three stages therefore holds fetch for three consecutive cycles.
- R6: A return in writeback sets `pc_sel`=2 (RETURN_ADDR) and releases fetch.
- R7: A conditional branch (class 5) in execute with `e_cond_fail`=1 gives `bubble` bits 1 and 2 set, `stall` bit 1 clear and `pc_sel`=1 (FALL_THROUGH). With `e_cond_fail`=0 the branch causes nothing. When a return is also in decode, fetch bit 0 of `stall` is also set.
- R8: When a load/use hazard and a return hazard occur together, decode is held rather than bubbled: `stall`=5'b00011 and `bubble`=5'b00100.
- R9: Out of reset, the memory and writeback registers are never stalled or bubbled, and no stage is stalled and bubbled at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, sampled only by the embedded properties |
| rst_n | input | 1 | Active-low reset |
| d_cls | input | 3 | Operation class in decode |
| d_src_a | input | 4 | First source register read in decode |
| d_src_b | input | 4 | Second source register read in decode |
| e_cls | input | 3 | Operation class in execute |
| e_dst_m | input | 4 | Register written from memory by the execute instruction |
| e_cond_fail | input | 1 | Branch condition in execute evaluated false |
| m_cls | input | 3 | Operation class in memory |
| w_cls | input | 3 | Operation class in writeback |
| stall | output | 5 | Per-stage hold, bit 0 fetch to bit 4 writeback |
| bubble | output | 5 | Per-stage no-op insertion, same bit order |
| pc_sel | output | 2 | Next fetch address: 0 predicted, 1 fall-through, 2 return address |

## Verification
A wrong register match shows up in the same cycle as a missing decode stall or a spurious execute bubble. The pipeline would then either consume a stale load value or lose one cycle of throughput. A broken return detector shows up as a fetch stall shorter or longer than three cycles, visible on `stall[0]` across the replayed sequence. A fault in mispredict handling shows up in the resolving cycle as `pc_sel` not equal to fall-through, or as wrong-path instructions not bubbled. Each scenario drives stage contents cycle by cycle and compares all three outputs in every cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int NUM_STAGES = 5;
  localparam int REG_W      = 4;
  localparam int CLS_W      = 3;
  localparam int ST_F = 0;
  localparam int ST_D = 1;
  localparam int ST_E = 2;
  localparam int ST_M = 3;
  localparam int ST_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP   = 3'd0,
    CLS_ALU   = 3'd1,
    CLS_LOAD  = 3'd2,
    CLS_POP   = 3'd3,
    CLS_STORE = 3'd4,
    CLS_JCOND = 3'd5,
    CLS_RET   = 3'd6,
    CLS_OTHER = 3'd7
  } op_cls_e;

  typedef enum logic [1:0] {
    PC_PREDICT   = 2'd0,
    PC_FALLTHRU  = 2'd1,
    PC_RETADDR   = 2'd2
  } pc_sel_e;

  typedef struct packed {
    logic load_use;
    logic ret_wait;
    logic mispredict;
  } hazards_t;
endpackage

// File: rtl/hazard_detect.sv
module hazard_detect
  import hazard_pkg::*;
#(
  parameter int RW = REG_W,
  parameter logic [RW-1:0] NO_REG = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CLS_W-1:0] d_cls,
  input  logic [RW-1:0]   d_src_a,
  input  logic [RW-1:0]   d_src_b,
  input  logic [CLS_W-1:0] e_cls,
  input  logic [RW-1:0]   e_dst_m,
  input  logic            e_cond_fail,
  input  logic [CLS_W-1:0] m_cls,
  output hazards_t        haz
);
  logic e_is_load;
  logic match_a, match_b;

  always_comb begin
    e_is_load = (e_cls == CLS_LOAD) || (e_cls == CLS_POP);
    match_a   = (d_src_a != NO_REG) && (d_src_a == e_dst_m);
    match_b   = (d_src_b != NO_REG) && (d_src_b == e_dst_m);
    haz.load_use   = e_is_load && (e_dst_m != NO_REG) && (match_a || match_b);
    haz.ret_wait   = (d_cls == CLS_RET) || (e_cls == CLS_RET) || (m_cls == CLS_RET);
    haz.mispredict = (e_cls == CLS_JCOND) && e_cond_fail;
  end

  // R4: a no-register ID on every side can never raise a load/use hazard
  assert_noreg_never_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (e_dst_m == NO_REG) |-> !haz.load_use);
  // a load/use hazard and a mispredict need different execute classes
  assert_loaduse_excl_mispredict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(haz.load_use && haz.mispredict));
endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import hazard_pkg::*;
#(
  parameter int NS = NUM_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hazards_t      haz,
  output logic [NS-1:0] stall,
  output logic [NS-1:0] bubble
);
  logic [NS-1:0] stall_run, bubble_run;

  always_comb begin
    stall_run  = '0;
    bubble_run = '0;
    stall_run[ST_F]  = haz.load_use || haz.ret_wait;
    stall_run[ST_D]  = haz.load_use;
    bubble_run[ST_D] = haz.mispredict || (haz.ret_wait && !haz.load_use);
    bubble_run[ST_E] = haz.mispredict || haz.load_use;
  end

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_stage
      always_comb begin
        if (!rst_n) begin
          stall[s]  = 1'b0;
          bubble[s] = (s != ST_F);
        end else begin
          stall[s]  = stall_run[s];
          bubble[s] = bubble_run[s];
        end
      end
      // R9: a register is either held or flushed, never both
      assert_stall_bubble_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall[s] && bubble[s]));
    end
  endgenerate

  // R9: memory and writeback registers always advance normally
  assert_late_stages_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stall[ST_M] && !stall[ST_W] && !bubble[ST_M] && !bubble[ST_W]);
  // R8: a load/use hazard holds decode even when a return waits
  assert_loaduse_holds_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    haz.load_use |-> (stall[ST_D] && !bubble[ST_D] && bubble[ST_E]));
  // R5: a waiting return always freezes fetch
  assert_ret_freezes_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    haz.ret_wait |-> stall[ST_F]);
endmodule

// File: rtl/pc_select.sv
module pc_select
  import hazard_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  hazards_t        haz,
  input  logic [CLS_W-1:0] w_cls,
  output pc_sel_e         pc_sel
);
  always_comb begin
    if (!rst_n)              pc_sel = PC_PREDICT;
    else if (haz.mispredict) pc_sel = PC_FALLTHRU;
    else if (w_cls == CLS_RET) pc_sel = PC_RETADDR;
    else                     pc_sel = PC_PREDICT;
  end

  // R7: a mispredict always redirects to the fall-through path
  assert_mispredict_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    haz.mispredict |-> (pc_sel == PC_FALLTHRU));
  // R6: the return address is chosen only for a return in writeback
  assert_retaddr_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel == PC_RETADDR) |-> (w_cls == CLS_RET));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int NS = NUM_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_W-1:0] d_cls,
  input  logic [RW-1:0]    d_src_a,
  input  logic [RW-1:0]    d_src_b,
  input  logic [CLS_W-1:0] e_cls,
  input  logic [RW-1:0]    e_dst_m,
  input  logic             e_cond_fail,
  input  logic [CLS_W-1:0] m_cls,
  input  logic [CLS_W-1:0] w_cls,
  output logic [NS-1:0]    stall,
  output logic [NS-1:0]    bubble,
  output logic [1:0]       pc_sel
);
  hazards_t haz;
  pc_sel_e  sel;

  hazard_detect #(.RW(RW)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .d_cls(d_cls), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .e_cls(e_cls), .e_dst_m(e_dst_m), .e_cond_fail(e_cond_fail),
    .m_cls(m_cls), .haz(haz)
  );

  stage_ctrl #(.NS(NS)) u_stage (
    .clk(clk), .rst_n(rst_n), .haz(haz), .stall(stall), .bubble(bubble)
  );

  pc_select u_pc (
    .clk(clk), .rst_n(rst_n), .haz(haz), .w_cls(w_cls), .pc_sel(sel)
  );

  assign pc_sel = sel;

  // R1: reset forces every stage after fetch to a no-op
  assert_reset_flush_R1: assert property (@(posedge clk)
    !rst_n |-> (stall == '0 && bubble == {{(NS-1){1'b1}}, 1'b0}));
endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] d_cls = 3'd0, e_cls = 3'd0, m_cls = 3'd0, w_cls = 3'd0;
  logic [3:0] d_src_a = 4'hF, d_src_b = 4'hF, e_dst_m = 4'hF;
  logic       e_cond_fail = 1'b0;
  logic [4:0] stall, bubble;
  logic [1:0] pc_sel;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hazard_ctrl i_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .d_cls(d_cls), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .e_cls(e_cls), .e_dst_m(e_dst_m), .e_cond_fail(e_cond_fail),
    .m_cls(m_cls), .w_cls(w_cls), .stall(stall), .bubble(bubble), .pc_sel(pc_sel)
  );

  task automatic drive(input logic [2:0] dc, input logic [3:0] sa, input logic [3:0] sb,
                       input logic [2:0] ec, input logic [3:0] dm, input logic cf,
                       input logic [2:0] mc, input logic [2:0] wc);
    @(negedge clk);
    d_cls = dc; d_src_a = sa; d_src_b = sb; e_cls = ec; e_dst_m = dm;
    e_cond_fail = cf; m_cls = mc; w_cls = wc;
    #2;
  endtask

  task automatic expect_out(input string req, input logic [4:0] es, input logic [4:0] eb,
                            input logic [1:0] ep);
    n_checks++;
    if (stall !== es || bubble !== eb || pc_sel !== ep) begin
      n_fail++;
      $display("FAIL %s: stall=%b bubble=%b pc_sel=%0d expected stall=%b bubble=%b pc_sel=%0d",
               req, stall, bubble, pc_sel, es, eb, ep);
    end
  endtask

  task automatic t_reset;
    #3 expect_out("R1", 5'b00000, 5'b11110, 2'd0);
    drive(3'd6, 4'd1, 4'd1, 3'd2, 4'd1, 1'b1, 3'd6, 3'd6);
    expect_out("R1", 5'b00000, 5'b11110, 2'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_forwarding;
    drive(3'd1, 4'd3, 4'd4, 3'd1, 4'd3, 1'b0, 3'd0, 3'd0);
    expect_out("R2 alu in execute", 5'b0, 5'b0, 2'd0);
    drive(3'd1, 4'd5, 4'd2, 3'd4, 4'd5, 1'b0, 3'd1, 3'd1);
    expect_out("R2 store in execute", 5'b0, 5'b0, 2'd0);
    drive(3'd1, 4'd7, 4'd2, 3'd0, 4'd7, 1'b0, 3'd2, 3'd0);
    expect_out("R3 load in memory no stall", 5'b0, 5'b0, 2'd0);
  endtask

  task automatic t_load_use;
    drive(3'd1, 4'd3, 4'd9, 3'd2, 4'd3, 1'b0, 3'd0, 3'd0);
    expect_out("R3 load match src a", 5'b00011, 5'b00100, 2'd0);
    drive(3'd4, 4'd1, 4'd6, 3'd3, 4'd6, 1'b0, 3'd0, 3'd0);
    expect_out("R3 pop match src b", 5'b00011, 5'b00100, 2'd0);
    drive(3'd1, 4'd1, 4'd2, 3'd2, 4'd3, 1'b0, 3'd0, 3'd0);
    expect_out("R3 load no match", 5'b0, 5'b0, 2'd0);
    drive(3'd1, 4'hF, 4'hF, 3'd2, 4'hF, 1'b0, 3'd0, 3'd0);
    expect_out("R4 no-register id", 5'b0, 5'b0, 2'd0);
  endtask

  task automatic t_return;
    drive(3'd6, 4'hF, 4'hF, 3'd1, 4'hF, 1'b0, 3'd0, 3'd0);
    expect_out("R5 ret in decode", 5'b00001, 5'b00010, 2'd0);
    drive(3'd0, 4'hF, 4'hF, 3'd6, 4'hF, 1'b0, 3'd1, 3'd0);
    expect_out("R5 ret in execute", 5'b00001, 5'b00010, 2'd0);
    drive(3'd0, 4'hF, 4'hF, 3'd0, 4'hF, 1'b0, 3'd6, 3'd1);
    expect_out("R5 ret in memory", 5'b00001, 5'b00010, 2'd0);
    drive(3'd0, 4'hF, 4'hF, 3'd0, 4'hF, 1'b0, 3'd0, 3'd6);
    expect_out("R6 ret in writeback", 5'b0, 5'b0, 2'd2);
  endtask

  task automatic t_branch;
    drive(3'd1, 4'd1, 4'd2, 3'd5, 4'hF, 1'b1, 3'd0, 3'd0);
    expect_out("R7 mispredict", 5'b0, 5'b00110, 2'd1);
    drive(3'd1, 4'd1, 4'd2, 3'd5, 4'hF, 1'b0, 3'd0, 3'd0);
    expect_out("R7 taken branch correct", 5'b0, 5'b0, 2'd0);
    drive(3'd6, 4'hF, 4'hF, 3'd5, 4'hF, 1'b1, 3'd0, 3'd0);
    expect_out("R7 mispredict with ret in decode", 5'b00001, 5'b00110, 2'd1);
  endtask

  task automatic t_priority;
    drive(3'd6, 4'd4, 4'hF, 3'd2, 4'd4, 1'b0, 3'd0, 3'd0);
    expect_out("R8 load/use with ret in decode", 5'b00011, 5'b00100, 2'd0);
    drive(3'd1, 4'd4, 4'hF, 3'd3, 4'd4, 1'b0, 3'd6, 3'd0);
    expect_out("R8 load/use with ret in memory", 5'b00011, 5'b00100, 2'd0);
    expect_out("R9 late stages free", {2'b00, stall[2:0]}, {2'b00, bubble[2:0]}, pc_sel);
  endtask

  initial begin
    t_reset();
    t_forwarding();
    t_load_use();
    t_return();
    t_branch();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule